// File: doc/BRIEF.md
# Configurable PAL output macrocell

This block is one output cell of a small programmable array logic device. An external AND array supplies a set of product terms. The cell ORs them, applies a programmable polarity inversion, and can optionally pass the result through a D flip-flop clocked by the device clock. It then drives a pad value and a tri-state enable, and returns a feedback bit to the AND array.

Three configuration bits select the cell's mode: a global register-allow bit, a global emulation bit and a local mode bit. A fourth local bit selects the output polarity. The mode code steers four selections:

- how many terms reach the OR gate;
- where the buffer enable comes from;
- what the pad shows;
- where the feedback bit originates.

The pad is modelled as a driven value `pad_o` with an enable `pad_oe_o`. The level actually present on the pin returns on `pad_i`.

Top module: `pal_macrocell`

## Requirements
- R1: Registered mode is code register-allow=0, emulation=1, local-mode=0. On each rising clock edge the flip-flop loads the OR of all eight terms after polarity. `pad_o` and `fb_o` both show the flip-flop output. `pad_oe_o` equals the inverse of the active-low `oe_ni`.
- R2: Combinatorial I/O mode is emulation=1, local-mode=1, with either value of register-allow. `pad_o` is the OR of terms 0 to 6 after polarity. `pad_oe_o` equals term 7. `fb_o` equals the pin level `pad_i`.
- R3: Dedicated output mode is register-allow=1, emulation=0, local-mode=0. `pad_o` is the OR of all eight terms after polarity. `pad_oe_o` is always 1. `fb_o` equals `pad_i`.
- R4: Dedicated input mode is register-allow=1, emulation=0, local-mode=1. `pad_oe_o` is 0, `pad_o` is 0, and `fb_o` equals the adjacent pin input `adj_i`.
- R5: With `pol_i`=1 the output is active high and shows the OR result unchanged. With `pol_i`=0 it is active low and shows the inverted result. This holds in every driving mode, registered mode included.
- R6: The codes register-allow=0 with emulation=0, and the code 1,1,0, are invalid. In those codes the cell behaves as a dedicated input (R4) and `bad_cfg_o` is 1. In every valid code `bad_cfg_o` is 0.
- R7: `sync_clr_i` high at a rising edge clears the flip-flop to 0 instead of loading it. Low `rst_ni` clears it asynchronously.
- R8: In combinatorial I/O mode, term 7 has no effect on `pad_o`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Device clock, rising edge |
| rst_ni | input | 1 | Asynchronous active-low reset |
| sync_clr_i | input | 1 | Synchronous power-up clear of the flip-flop |
| pterm_i | input | 8 | Product terms from the AND array |
| oe_ni | input | 1 | Active-low output enable pin |
| adj_i | input | 1 | Adjacent pin level |
| pad_i | input | 1 | Level present on this cell's pin |
| reg_allow_i | input | 1 | Global register-allow configuration bit |
| emu_mode_i | input | 1 | Global emulation configuration bit |
| cell_mode_i | input | 1 | Local mode configuration bit |
| pol_i | input | 1 | Local polarity bit, 1 = active high |
| pad_o | output | 1 | Value driven onto the pin |
| pad_oe_o | output | 1 | Tri-state enable for the pin |
| fb_o | output | 1 | Feedback to the AND array |
| bad_cfg_o | output | 1 | Invalid configuration code flag |

## Verification
The bench builds the cell with its default eight terms. At that width every one of the sixteen configuration and polarity codes can be combined with all 256 term patterns, both `oe_ni` levels, both `adj_i` levels and both external pin levels. This reaches every mode, every invalid code and every term-7 interaction. The bench models the pin as the driven value when enabled and the external level otherwise, so the feedback path is exercised under both conditions. The registered path is checked one edge after each pattern, with separate checks for the synchronous clear and the asynchronous reset.

// File: rtl/pal_mc_pkg.sv
package pal_mc_pkg;
  typedef enum logic [2:0] {
    MODE_REG,
    MODE_CIO,
    MODE_DOUT,
    MODE_DIN,
    MODE_BAD
  } mc_mode_e;
endpackage

// File: rtl/pal_mc_decode.sv
module pal_mc_decode
  import pal_mc_pkg::*;
(
  input  logic     reg_allow_i,
  input  logic     emu_mode_i,
  input  logic     cell_mode_i,
  output mc_mode_e mode_o,
  output logic     bad_o
);
  always_comb begin
    unique case ({reg_allow_i, emu_mode_i, cell_mode_i})
      3'b010:         mode_o = MODE_REG;
      3'b011, 3'b111: mode_o = MODE_CIO;
      3'b100:         mode_o = MODE_DOUT;
      3'b101:         mode_o = MODE_DIN;
      default:        mode_o = MODE_BAD;
    endcase
  end

  assign bad_o = (mode_o == MODE_BAD);
endmodule

// File: rtl/pal_mc_sop.sv
module pal_mc_sop #(
  parameter int unsigned NUM_TERMS = 8
) (
  input  logic [NUM_TERMS-1:0] pterm_i,
  input  logic                 pol_i,
  output logic                 full_o,
  output logic                 short_o
);
  localparam int unsigned SHORT_TERMS = NUM_TERMS - 1;

  logic or_full, or_short;

  assign or_full  = |pterm_i;
  assign or_short = |pterm_i[SHORT_TERMS-1:0];

  // XOR acts as a programmable inverter: pol=1 keeps the OR result.
  assign full_o  = or_full  ^ ~pol_i;
  assign short_o = or_short ^ ~pol_i;
endmodule

// File: rtl/pal_mc_reg.sv
module pal_mc_reg (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic sync_clr_i,
  input  logic d_i,
  output logic q_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         q_o <= 1'b0;
    else if (sync_clr_i) q_o <= 1'b0;
    else                 q_o <= d_i;
  end

  p_reg_load_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sync_clr_i |=> (q_o == $past(d_i)));

  p_sync_clr_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sync_clr_i |=> (q_o == 1'b0));
endmodule

// File: rtl/pal_macrocell.sv
module pal_macrocell
  import pal_mc_pkg::*;
#(
  parameter int unsigned NUM_TERMS = 8
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 sync_clr_i,
  input  logic [NUM_TERMS-1:0] pterm_i,
  input  logic                 oe_ni,
  input  logic                 adj_i,
  input  logic                 pad_i,
  input  logic                 reg_allow_i,
  input  logic                 emu_mode_i,
  input  logic                 cell_mode_i,
  input  logic                 pol_i,
  output logic                 pad_o,
  output logic                 pad_oe_o,
  output logic                 fb_o,
  output logic                 bad_cfg_o
);
  localparam int unsigned EN_TERM = NUM_TERMS - 1;

  mc_mode_e mode;
  logic     sum_full, sum_short, q;

  pal_mc_decode u_decode (
    .reg_allow_i (reg_allow_i),
    .emu_mode_i  (emu_mode_i),
    .cell_mode_i (cell_mode_i),
    .mode_o      (mode),
    .bad_o       (bad_cfg_o)
  );

  pal_mc_sop #(.NUM_TERMS(NUM_TERMS)) u_sop (
    .pterm_i (pterm_i),
    .pol_i   (pol_i),
    .full_o  (sum_full),
    .short_o (sum_short)
  );

  // Loads every edge; only visible in registered mode.
  pal_mc_reg u_reg (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .sync_clr_i (sync_clr_i),
    .d_i        (sum_full),
    .q_o        (q)
  );

  always_comb begin
    pad_o    = 1'b0;
    pad_oe_o = 1'b0;
    fb_o     = adj_i;
    unique case (mode)
      MODE_REG: begin
        pad_o    = q;
        pad_oe_o = ~oe_ni;
        fb_o     = q;
      end
      MODE_CIO: begin
        pad_o    = sum_short;
        pad_oe_o = pterm_i[EN_TERM];
        fb_o     = pad_i;
      end
      MODE_DOUT: begin
        pad_o    = sum_full;
        pad_oe_o = 1'b1;
        fb_o     = pad_i;
      end
      default: ;
    endcase
  end

  p_reg_fb_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!reg_allow_i && emu_mode_i && !cell_mode_i) |-> (fb_o == pad_o && pad_oe_o == !oe_ni));

  p_cio_en_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (emu_mode_i && cell_mode_i) |-> (pad_oe_o == pterm_i[EN_TERM] && fb_o == pad_i));

  p_dout_en_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_allow_i && !emu_mode_i && !cell_mode_i) |-> pad_oe_o);

  p_din_off_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (reg_allow_i && !emu_mode_i && cell_mode_i) |-> (!pad_oe_o && fb_o == adj_i));

  p_bad_off_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    bad_cfg_o |-> (!pad_oe_o && !pad_o && fb_o == adj_i));
endmodule

// File: tb/pal_macrocell_tb.sv
module pal_macrocell_tb;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       sclr = 1'b0;
  logic [7:0] pt = '0;
  logic       oe_n = 1'b0, adj = 1'b0, ext = 1'b0;
  logic       ra = 1'b0, em = 1'b1, lm = 1'b0, pol = 1'b1;
  logic       pad_in, pad, pad_oe, fb, bad;

  int vecs = 0;
  int errs = 0;

  always #2 clk = ~clk;

  assign pad_in = pad_oe ? pad : ext;

  pal_macrocell u_dut (
    .clk_i (clk), .rst_ni (rst_n), .sync_clr_i (sclr), .pterm_i (pt),
    .oe_ni (oe_n), .adj_i (adj), .pad_i (pad_in),
    .reg_allow_i (ra), .emu_mode_i (em), .cell_mode_i (lm), .pol_i (pol),
    .pad_o (pad), .pad_oe_o (pad_oe), .fb_o (fb), .bad_cfg_o (bad)
  );

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    if (act !== exp) begin
      errs++;
      $display("FAIL %s %s: actual %b expected %b (cfg=%b%b%b pol=%b pt=%h oe_n=%b adj=%b ext=%b)",
               req, what, act, exp, ra, em, lm, pol, pt, oe_n, adj, ext);
    end
  endtask

  initial begin
    #400000;
    errs++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("  == %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end

  initial begin
    logic q_exp, sf, ss, e_pad, e_oe, e_fb, e_bad, pin;
    string req;

    // Reset state: registered mode, flip-flop cleared (R7).
    pt = 8'hff;
    #3;
    vecs++;
    chk("R7", "reset pad", pad, 1'b0);
    chk("R7", "reset fb", fb, 1'b0);
    @(negedge clk);
    rst_n = 1'b1;

    // Load a 1, then the synchronous clear wins over the load (R7).
    @(posedge clk); #1;
    vecs++;
    chk("R1", "reg load", pad, 1'b1);
    @(negedge clk);
    sclr = 1'b1;
    @(posedge clk); #1;
    vecs++;
    chk("R7", "sync clr", pad, 1'b0);
    @(negedge clk);
    sclr = 1'b0;

    for (int c = 0; c < 16; c++) begin
      for (int p = 0; p < 256; p++) begin
        for (int m = 0; m < 8; m++) begin
          @(negedge clk);
          {ra, em, lm, pol} = 4'(c);
          pt = 8'(p);
          {oe_n, adj, ext} = 3'(m);
          sf = (|pt) ^ ~pol;       // R5 polarity
          ss = (|pt[6:0]) ^ ~pol;  // R8 term 7 excluded
          q_exp = sf;
          e_bad = 1'b0;
          if ({ra, em, lm} == 3'b010) begin
            req = "R1"; e_pad = q_exp; e_oe = ~oe_n; e_fb = q_exp;
          end else if ({em, lm} == 2'b11) begin
            req = "R2/R8"; e_pad = ss; e_oe = pt[7];
            e_fb = e_oe ? ss : ext;
          end else if ({ra, em, lm} == 3'b100) begin
            req = "R3"; e_pad = sf; e_oe = 1'b1; e_fb = sf;
          end else if ({ra, em, lm} == 3'b101) begin
            req = "R4"; e_pad = 1'b0; e_oe = 1'b0; e_fb = adj;
          end else begin
            req = "R6"; e_pad = 1'b0; e_oe = 1'b0; e_fb = adj; e_bad = 1'b1;
          end
          @(posedge clk); #1;
          vecs++;
          pin = pad_oe ? pad : ext;
          chk(req, "pad_oe", pad_oe, e_oe);
          chk(req, "pad", pad, e_pad);
          chk(req, "fb", fb, e_fb);
          chk("R6", "bad_cfg", bad, e_bad);
          if (!e_oe && req != "R1") chk(req, "pin", pin, ext);
        end
      end
    end

    $display("  == %0d vectors applied, %0d miscompares ==", vecs, errs);
    $finish;
  end
endmodule